// File: doc/BRIEF.md
# Opcode-Nibble Bus ALU

This block is the arithmetic and logic unit of a small 8-bit datapath. It reads two general-purpose operands, A and B, from registers held outside the block and computes one result, which it places on a shared bus rather than writing it back into either register. The only control line it needs is a single ALU-active strobe. The operation itself is taken from the low nibble of the current opcode, so the control sequencer needs no separate line for each function.

Bits [3:1] of that nibble choose one of eight functions. Bit 0 feeds the adder: it inverts B and supplies the carry-in, so one adder performs both addition and subtraction. The block also keeps a registered carry status flag. A later conditional jump reads this flag, and the compare operation exists to set it without putting anything on the bus. The bus output is qualified by a drive flag: while that flag is low the output value is zero, which stands in for a released bus.

The design has one piece of state, the carry register. It has two states: held, and loaded on an ALU-active edge. It has two transitions: "load", on a clock edge with ALU-active high, and "clear", on a clock edge with reset high. Reset takes priority over load.

Top module: `nalu_bus_alu`

## Requirements
- R1: `bus_drive` is 1 and `bus_out` carries the result only when `alu_act` is 1 and the function is not compare. Otherwise `bus_drive` is 0 and `bus_out` is 0.
- R2: Function 000 (`op_nib[3:1]`) with `op_nib[0]`=0 puts (A+B) mod 256 on the bus, and the carry takes the adder carry-out.
- R3: Function 000 with `op_nib[0]`=1 puts (A+~B+1) mod 256 on the bus, which is A−B, and the carry becomes 1 exactly when A ≥ B.
- R4: Functions 001, 010 and 011 put A AND B, A OR B and A XOR B on the bus, and they clear the carry.
- R5: Function 100 (compare) leaves the bus undriven and sets the carry to 1 exactly when A ≥ B, whatever the value of `op_nib[0]`.
- R6: Function 101 puts the bitwise complement of B on the bus and clears the carry.
- R7: Function 110 puts A shifted left by one, with a zero filled in, on the bus and loads the carry with A[7]. Function 111 puts A shifted right by one, with a zero filled in, and loads the carry with A[0].
- R8: For every function other than 000, `op_nib[0]` has no effect on `bus_out`, `bus_drive` or the carry.
- R9: `carry_q` changes only on a clock edge where `alu_act` is 1. On any other edge it holds its value.
- R10: A synchronous reset (`rst`=1 at a clock edge) clears `carry_q`, even when `alu_act` is 1 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset for the carry flag |
| alu_act | input | 1 | ALU-active control line |
| op_nib | input | 4 | Low nibble of the current opcode |
| opa | input | 8 | Operand A from its register |
| opb | input | 8 | Operand B from its register |
| bus_out | output | 8 | Result toward the shared bus; zero when not driving |
| bus_drive | output | 1 | High while the ALU owns the bus |
| carry_q | output | 1 | Registered carry status flag |

## Verification
The bench sweeps all sixteen opcode nibbles against every value of A and a spread of B values. The B values include 0x00, 0x7F, 0x80, 0xFF and, through the A sweep, every A = B case.

The points it targets each have a typical failure:
- The equality boundary of subtract and compare. A carry polarity that is inverted or off by one gives the wrong flag when A equals B.
- A compare that honours bit 0, or that leaks its difference onto the bus.
- Shift carries taken from the wrong end of A.
- Logic ops that keep a stale carry instead of clearing it.
- Idle cycles that disturb the flag.
- A reset that loses to a simultaneous ALU-active load.

// File: rtl/nalu_pkg.sv
package nalu_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_AND = 3'd1,
        FN_OR  = 3'd2,
        FN_XOR = 3'd3,
        FN_CMP = 3'd4,
        FN_INV = 3'd5,
        FN_SHL = 3'd6,
        FN_SHR = 3'd7
    } nalu_fn_e;

    typedef struct packed {
        nalu_fn_e fn;
        logic     b_invert;
        logic     carry_in;
        logic     use_adder;
        logic     drives_bus;
    } nalu_ctl_t;

endpackage

// File: rtl/nalu_decode.sv
module nalu_decode
    import nalu_pkg::*;
(
    input  logic [NIB_W-1:0] op_nib,
    output nalu_ctl_t        ctl
);

    nalu_fn_e fn_sel;

    assign fn_sel = nalu_fn_e'(op_nib[NIB_W-1:1]);

    always_comb begin
        ctl.fn         = fn_sel;
        ctl.b_invert   = 1'b0;
        ctl.carry_in   = 1'b0;
        ctl.use_adder  = 1'b0;
        ctl.drives_bus = 1'b1;
        unique case (fn_sel)
            FN_ADD: begin
                ctl.b_invert  = op_nib[0];
                ctl.carry_in  = op_nib[0];
                ctl.use_adder = 1'b1;
            end
            FN_CMP: begin
                ctl.b_invert   = 1'b1;
                ctl.carry_in   = 1'b1;
                ctl.use_adder  = 1'b1;
                ctl.drives_bus = 1'b0;
            end
            FN_AND, FN_OR, FN_XOR, FN_INV, FN_SHL, FN_SHR: begin
                ctl.use_adder = 1'b0;
            end
            default: begin
                ctl.use_adder = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nalu_adder.sv
module nalu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         b_invert,
    input  logic         carry_in,
    output logic [W-1:0] sum,
    output logic         carry_out
);

    logic [W:0]   chain;
    logic [W-1:0] b_eff;

    assign chain[0] = carry_in;
    assign b_eff    = b_invert ? ~b : b;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
    end

    assign carry_out = chain[W];

endmodule

// File: rtl/nalu_logic.sv
module nalu_logic
    import nalu_pkg::*;
#(
    parameter int W = 8
) (
    input  nalu_fn_e     fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output logic         carry_out
);

    always_comb begin
        result    = '0;
        carry_out = 1'b0;
        unique case (fn)
            FN_AND: result = a & b;
            FN_OR:  result = a | b;
            FN_XOR: result = a ^ b;
            FN_INV: result = ~b;
            FN_SHL: begin
                result    = {a[W-2:0], 1'b0};
                carry_out = a[W-1];
            end
            FN_SHR: begin
                result    = {1'b0, a[W-1:1]};
                carry_out = a[0];
            end
            FN_ADD, FN_CMP: begin
                result    = '0;
                carry_out = 1'b0;
            end
            default: begin
                result    = '0;
                carry_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nalu_bus_alu.sv
module nalu_bus_alu
    import nalu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alu_act,
    input  logic [NIB_W-1:0] op_nib,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    output logic [W-1:0]     bus_out,
    output logic             bus_drive,
    output logic             carry_q
);

    nalu_ctl_t    ctl;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] lg_res;
    logic         lg_cout;
    logic [W-1:0] result;
    logic         carry_nxt;

    nalu_decode u_decode (
        .op_nib (op_nib),
        .ctl    (ctl)
    );

    nalu_adder #(.W(W)) u_adder (
        .a         (opa),
        .b         (opb),
        .b_invert  (ctl.b_invert),
        .carry_in  (ctl.carry_in),
        .sum       (add_sum),
        .carry_out (add_cout)
    );

    nalu_logic #(.W(W)) u_logic (
        .fn        (ctl.fn),
        .a         (opa),
        .b         (opb),
        .result    (lg_res),
        .carry_out (lg_cout)
    );

    always_comb begin
        result    = ctl.use_adder ? add_sum  : lg_res;
        carry_nxt = ctl.use_adder ? add_cout : lg_cout;
    end

    // Bus output process
    always_comb begin
        bus_drive = alu_act & ctl.drives_bus;
        bus_out   = bus_drive ? result : '0;
    end

    // Carry state register: clear on reset, load on ALU-active, else hold
    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
        end else if (alu_act) begin
            carry_q <= carry_nxt;
        end
    end

    // R1
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !alu_act |-> (!bus_drive && bus_out == '0));

    // R5
    a_r5_cmp_silent: assert property (@(posedge clk) disable iff (rst)
        (alu_act && op_nib[3:1] == 3'b100) |-> !bus_drive);

    // R2
    a_r2_add_sum: assert property (@(posedge clk) disable iff (rst)
        (alu_act && op_nib == 4'h0) |-> (bus_drive && bus_out == W'(opa + opb)));

    // R9
    a_r9_carry_hold: assert property (@(posedge clk) disable iff (rst)
        !alu_act |=> $stable(carry_q));

    // R10
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (carry_q == 1'b0));

    // R7
    a_r7_shl_carry: assert property (@(posedge clk) disable iff (rst)
        (alu_act && op_nib[3:1] == 3'b110) |=> (carry_q == $past(opa[W-1])));

    // R4
    a_r4_logic_clears: assert property (@(posedge clk) disable iff (rst)
        (alu_act && op_nib[3:1] == 3'b011) |=> !carry_q);

endmodule

// File: tb/nalu_bus_alu_tb_top.sv
module nalu_bus_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alu_act = 1'b0;
    logic [3:0] op_nib = 4'h0;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic [7:0] bus_out;
    logic       bus_drive;
    logic       carry_q;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nalu_bus_alu dut_i (
        .clk       (clk),
        .rst       (rst),
        .alu_act   (alu_act),
        .op_nib    (op_nib),
        .opa       (opa),
        .opb       (opb),
        .bus_out   (bus_out),
        .bus_drive (bus_drive),
        .carry_q   (carry_q)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below 190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h (op=%0h a=%0h b=%0h act=%0b)",
                     tag, act, exp, op_nib, opa, opb, alu_act);
        end
    endtask

    function automatic string req_tag(input logic [3:0] op);
        if (op[3:1] != 3'b000 && op[0]) return "R8";
        case (op[3:1])
            3'b000:  return op[0] ? "R3" : "R2";
            3'b100:  return "R5";
            3'b101:  return "R6";
            3'b110, 3'b111: return "R7";
            default: return "R4";
        endcase
    endfunction

    // Apply one ALU-active vector; check the bus before the edge, carry after.
    task automatic run_vec(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [8:0] wide;
        logic [7:0] e_res;
        logic       e_drv;
        logic       e_c;
        string      tag;
        @(negedge clk);
        alu_act = 1'b1;
        op_nib  = op;
        opa     = a;
        opb     = b;
        e_drv = 1'b1;
        e_res = 8'h00;
        e_c   = 1'b0;
        case (op[3:1])
            3'b000: begin
                wide  = op[0] ? ({1'b0, a} + {1'b0, ~b} + 9'd1) : ({1'b0, a} + {1'b0, b});
                e_res = wide[7:0];
                e_c   = wide[8];
                if (op[0]) e_c = (a >= b);
            end
            3'b001: e_res = a & b;
            3'b010: e_res = a | b;
            3'b011: e_res = a ^ b;
            3'b100: begin e_drv = 1'b0; e_c = (a >= b); end
            3'b101: e_res = ~b;
            3'b110: begin e_res = {a[6:0], 1'b0}; e_c = a[7]; end
            default: begin e_res = {1'b0, a[7:1]}; e_c = a[0]; end
        endcase
        tag = req_tag(op);
        #1;
        check({tag, " R1 drive"}, int'(bus_drive), int'(e_drv));
        check({tag, " bus"}, int'(bus_out), int'(e_res));
        @(posedge clk);
        #1;
        check({tag, " carry"}, int'(carry_q), int'(e_c));
    endtask

    task automatic idle_vec(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                            input logic exp_c);
        @(negedge clk);
        alu_act = 1'b0;
        op_nib  = op;
        opa     = a;
        opb     = b;
        #1;
        check("R1 idle drive", int'(bus_drive), 0);
        check("R1 idle bus", int'(bus_out), 0);
        @(posedge clk);
        #1;
        check("R9 carry hold", int'(carry_q), int'(exp_c));
    endtask

    initial begin
        logic [7:0] bv;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset state carry", int'(carry_q), 0);
        check("R1 reset state drive", int'(bus_drive), 0);
        @(negedge clk);
        rst = 1'b0;

        // Main sweep: all nibbles, all A, 18 B values
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int j = 0; j < 18; j++) begin
                    bv = (j < 16) ? 8'(j * 17) : ((j == 16) ? 8'h80 : 8'h7F);
                    run_vec(4'(op), 8'(a), bv);
                end
            end
        end

        // R9: idle cycles hold a set carry and a clear carry
        run_vec(4'hC, 8'h80, 8'h00);
        for (int k = 0; k < 16; k++) idle_vec(4'(k), 8'hFF, 8'h01, 1'b1);
        run_vec(4'h2, 8'h00, 8'h00);
        for (int k = 0; k < 16; k++) idle_vec(4'(k), 8'h80, 8'hFF, 1'b0);

        // R10: reset wins over a simultaneous carry-setting load
        run_vec(4'hE, 8'h01, 8'h00);
        @(negedge clk);
        rst     = 1'b1;
        alu_act = 1'b1;
        op_nib  = 4'hC;
        opa     = 8'hFF;
        @(posedge clk);
        #1;
        check("R10 reset over load", int'(carry_q), 0);
        @(negedge clk);
        rst     = 1'b0;
        alu_act = 1'b0;
        @(posedge clk);
        #1;
        check("R10 carry stays clear", int'(carry_q), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule